// File: doc/BRIEF.md
# I2C Control and Event Flag Unit

This block holds the control word and the sticky event flags of an I2C peripheral. Software reaches it over a simple register bus. The protocol engine reports what happens on the bus as one-cycle pulses: transmit ready, receive ready, address match, NACK, stop, transfer complete, transfer-complete reload, arbitration loss, bus error and overrun. Each pulse sets a flag. The flag stays set until software writes a one to its bit in a clear register.

The control word supplies three things. It has a master enable, and the block tells the pin drivers to release the lines while that enable is low. It has the noise-filter length and mode bits that the protocol engine reads. It has a set of enables that gate the flags onto one level-sensitive interrupt line and onto the TX and RX DMA request lines. The block also decides whether the engine should acknowledge the all-zero general-call address.

Three register offsets are decoded: 0 is the control word (read/write), 1 is the status word (read only), 2 is the clear word (write only, reads 0). Reads are registered, so read data appears one cycle after the read strobe.

Top module: `i2c_ctl_flags`

## Requirements
- R1: After a synchronous reset, the control word reads 0, the status word reads 0, `irq`, `dma_tx_req`, `dma_rx_req` and `gc_ack` are 0, and `line_release` is 1.
- R2: While control bit 0 (enable) is 0, every status flag is forced to 0 on the next clock and `line_release` is 1. Pulses that arrive while the block is disabled leave no flag behind.
- R3: Control bits 11:8 (filter length), bit 12 (analog filter off) and bit 13 (stretch disable) accept a write only when the enable held before the write is 0. Otherwise they keep their old values, and `cfg_*` outputs follow them.
- R4: Control bits 7 (TX), 6 (RX), 5 (address), 4 (NACK) and 3 (stop) each gate one flag onto `irq`. `irq` is a level output, registered one cycle after the flags, and stays high until the causing flags are cleared.
- R5: Control bit 2 gates both the transfer-complete flag (status bit 5) and the reload flag (status bit 6) onto `irq`.
- R6: Control bit 1 gates arbitration loss (status bit 7), bus error (bit 8) and overrun (bit 9) onto `irq`.
- R7: With control bit 17 at 0, an address-match pulse sets status bit 2, and writing 1 to clear bit 2 clears it. With control bit 17 at 1, the flag is held at 0.
- R8: With control bit 18 at 0, a stop pulse sets status bit 4, and clear bit 4 clears it. With control bit 18 at 1, the flag is held at 0.
- R9: When `rx_addr_vld` is high and `rx_addr` is 0, `gc_ack` goes high one cycle later exactly when the block is enabled and control bit 16 is 1. For any other address, `gc_ack` stays 0.
- R10: `dma_tx_req` is 1 one cycle after the transmit flag (status bit 0) and control bit 14 are both 1. `dma_rx_req` behaves the same with the receive flag (status bit 1) and control bit 15.
- R11: When an event pulse and a clear bit hit the same flag in the same cycle, the flag ends up set.
- R12: The status word packs the flags at bits 0 TX, 1 RX, 2 address, 3 NACK, 4 stop, 5 TC, 6 reload, 7 arbitration, 8 bus error, 9 overrun, with bits above reading 0. The clear word uses the same positions, and a 0 bit leaves its flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_pulse | input | 10 | One-cycle event pulses, same bit order as the status word |
| rx_addr | input | 7 | Received slave address from the engine |
| rx_addr_vld | input | 1 | `rx_addr` is valid this cycle |
| gc_ack | output | 1 | Acknowledge decision for a general-call address |
| irq | output | 1 | Combined level interrupt |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |
| line_release | output | 1 | Release SCL/SDA while disabled |
| cfg_filt_len | output | 4 | Digital filter length for the engine |
| cfg_anoff | output | 1 | Analog filter off |
| cfg_nostretch | output | 1 | Clock stretching disabled |

## Verification
One test writes the locked filter fields twice. The first write is made while the block is enabled and also clears the enable. A design that checks the new enable value instead of the old one would let that first write through. Another test fires a pulse and a clear at the same flag in the same cycle. A design where the clear wins would lose that event and read the flag as 0. The auto-clear tests check the status word and `irq` after an address or stop pulse, which catches a design that lets the flag set for one cycle. The shared TC and error enables are tested one source at a time, so a design that leaves one source off its group never raises `irq` for that source.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 2;
  localparam int NUM_FLAGS = 10;
  localparam int FILT_W    = 4;
  localparam int SLV_W     = 7;

  // register offsets
  localparam logic [ADDR_W-1:0] OFF_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] OFF_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] OFF_CLR  = 2'd2;

  // control word bit positions
  localparam int C_EN      = 0;
  localparam int C_ERR_IE  = 1;
  localparam int C_TC_IE   = 2;
  localparam int C_STOP_IE = 3;
  localparam int C_NACK_IE = 4;
  localparam int C_ADDR_IE = 5;
  localparam int C_RX_IE   = 6;
  localparam int C_TX_IE   = 7;
  localparam int C_FILT_LO = 8;
  localparam int C_ANOFF   = 12;
  localparam int C_NOSTR   = 13;
  localparam int C_TXDMA   = 14;
  localparam int C_RXDMA   = 15;
  localparam int C_GC      = 16;
  localparam int C_ADDR_AC = 17;
  localparam int C_STOP_AC = 18;
  localparam int C_TOP     = C_STOP_AC;

  // status / clear / event bit positions
  localparam int F_TX   = 0;
  localparam int F_RX   = 1;
  localparam int F_ADDR = 2;
  localparam int F_NACK = 3;
  localparam int F_STOP = 4;
  localparam int F_TC   = 5;
  localparam int F_TCR  = 6;
  localparam int F_ARLO = 7;
  localparam int F_BERR = 8;
  localparam int F_OVR  = 9;

  typedef struct packed {
    logic       stop_ac;
    logic       addr_ac;
    logic       gc_en;
    logic       rx_dma;
    logic       tx_dma;
    logic       nostretch;
    logic       anoff;
    logic [3:0] filt;
    logic       tx_ie;
    logic       rx_ie;
    logic       addr_ie;
    logic       nack_ie;
    logic       stop_ie;
    logic       tc_ie;
    logic       err_ie;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/i2c_cfg_reg.sv
module i2c_cfg_reg
  import i2c_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl
);
  localparam int CW = C_TOP + 1;

  ctrl_t nxt;
  ctrl_t wr_view;

  assign wr_view = ctrl_t'(wdata[CW-1:0]);

  always_comb begin
    nxt = ctrl;
    if (wr) begin
      nxt = wr_view;
      // fields tied to the bus timing accept writes only while disabled
      if (ctrl.en) begin
        nxt.filt      = ctrl.filt;
        nxt.anoff     = ctrl.anoff;
        nxt.nostretch = ctrl.nostretch;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else     ctrl <= nxt;
  end
endmodule

// File: rtl/i2c_evt_flags.sv
module i2c_evt_flags #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] hold0,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || !en || hold0[i]) flags[i] <= 1'b0;
      else if (set[i])            flags[i] <= 1'b1;
      else if (clr[i])            flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_irq_dma.sv
module i2c_irq_dma
  import i2c_ctl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  ctrl_t                ctrl,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic                 irq,
  output logic                 dma_tx_req,
  output logic                 dma_rx_req
);
  logic [NUM_FLAGS-1:0] mask;

  always_comb begin
    mask         = '0;
    mask[F_TX]   = ctrl.tx_ie;
    mask[F_RX]   = ctrl.rx_ie;
    mask[F_ADDR] = ctrl.addr_ie;
    mask[F_NACK] = ctrl.nack_ie;
    mask[F_STOP] = ctrl.stop_ie;
    mask[F_TC]   = ctrl.tc_ie;
    mask[F_TCR]  = ctrl.tc_ie;
    mask[F_ARLO] = ctrl.err_ie;
    mask[F_BERR] = ctrl.err_ie;
    mask[F_OVR]  = ctrl.err_ie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq        <= 1'b0;
      dma_tx_req <= 1'b0;
      dma_rx_req <= 1'b0;
    end else begin
      irq        <= |(flags & mask);
      dma_tx_req <= flags[F_TX] & ctrl.tx_dma;
      dma_rx_req <= flags[F_RX] & ctrl.rx_dma;
    end
  end
endmodule

// File: rtl/i2c_ctl_flags.sv
module i2c_ctl_flags
  import i2c_ctl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_FLAGS-1:0] evt_pulse,
  input  logic [SLV_W-1:0]     rx_addr,
  input  logic                 rx_addr_vld,
  output logic                 gc_ack,
  output logic                 irq,
  output logic                 dma_tx_req,
  output logic                 dma_rx_req,
  output logic                 line_release,
  output logic [FILT_W-1:0]    cfg_filt_len,
  output logic                 cfg_anoff,
  output logic                 cfg_nostretch
);
  localparam int CW = C_TOP + 1;

  ctrl_t                ctrl;
  logic                 ctrl_wr;
  logic                 clr_wr;
  logic [NUM_FLAGS-1:0] clr_vec;
  logic [NUM_FLAGS-1:0] hold0;
  logic [NUM_FLAGS-1:0] flags;

  assign ctrl_wr = bus_sel && bus_we && (bus_addr == OFF_CTRL);
  assign clr_wr  = bus_sel && bus_we && (bus_addr == OFF_CLR);
  assign clr_vec = clr_wr ? bus_wdata[NUM_FLAGS-1:0] : '0;

  always_comb begin
    hold0         = '0;
    hold0[F_ADDR] = ctrl.addr_ac;
    hold0[F_STOP] = ctrl.stop_ac;
  end

  i2c_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .wr    (ctrl_wr),
    .wdata (bus_wdata),
    .ctrl  (ctrl)
  );

  i2c_evt_flags #(.N(NUM_FLAGS)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .en    (ctrl.en),
    .set   (evt_pulse),
    .clr   (clr_vec),
    .hold0 (hold0),
    .flags (flags)
  );

  i2c_irq_dma u_irq (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .flags      (flags),
    .irq        (irq),
    .dma_tx_req (dma_tx_req),
    .dma_rx_req (dma_rx_req)
  );

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_we) begin
      unique case (bus_addr)
        OFF_CTRL: bus_rdata <= {{(DATA_W-CW){1'b0}}, ctrl};
        OFF_STAT: bus_rdata <= {{(DATA_W-NUM_FLAGS){1'b0}}, flags};
        default:  bus_rdata <= '0;
      endcase
    end
  end

  // general call acknowledge decision
  always_ff @(posedge clk) begin
    if (rst) gc_ack <= 1'b0;
    else     gc_ack <= rx_addr_vld && (rx_addr == '0) && ctrl.en && ctrl.gc_en;
  end

  assign line_release  = ~ctrl.en;
  assign cfg_filt_len  = ctrl.filt;
  assign cfg_anoff     = ctrl.anoff;
  assign cfg_nostretch = ctrl.nostretch;
endmodule

// File: rtl/i2c_ctl_flags_chk.sv
module i2c_ctl_flags_chk
  import i2c_ctl_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input ctrl_t                ctrl,
  input logic                 ctrl_wr,
  input logic [NUM_FLAGS-1:0] flags,
  input logic [NUM_FLAGS-1:0] evt_pulse,
  input logic [NUM_FLAGS-1:0] clr_vec,
  input logic                 irq,
  input logic                 dma_tx_req,
  input logic                 line_release
);
  // R2: disabled block holds no flags and releases the lines
  a_r2_disable_clears: assert property (@(posedge clk) disable iff (rst)
    !ctrl.en |=> (flags == '0));
  a_r2_release: assert property (@(posedge clk) disable iff (rst)
    !ctrl.en |-> line_release);

  // R3: locked fields do not move on a write while enabled
  a_r3_filt_locked: assert property (@(posedge clk) disable iff (rst)
    (ctrl.en && ctrl_wr) |=> $stable(ctrl.filt) && $stable(ctrl.nostretch) && $stable(ctrl.anoff));

  // R4: no flags means the interrupt drops next cycle
  a_r4_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    (flags == '0) |=> !irq);

  // R7 / R8: auto-clear holds the flags low
  a_r7_addr_autoclr: assert property (@(posedge clk) disable iff (rst)
    ctrl.addr_ac |=> !flags[F_ADDR]);
  a_r8_stop_autoclr: assert property (@(posedge clk) disable iff (rst)
    ctrl.stop_ac |=> !flags[F_STOP]);

  // R10: TX DMA request only from an enabled, set transmit flag
  a_r10_dma_tx: assert property (@(posedge clk) disable iff (rst)
    dma_tx_req |-> $past(flags[F_TX] && ctrl.tx_dma));

  // R11: set beats clear
  a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
    (ctrl.en && evt_pulse[F_TX] && clr_vec[F_TX]) |=> flags[F_TX]);
endmodule

bind i2c_ctl_flags i2c_ctl_flags_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .ctrl         (ctrl),
  .ctrl_wr      (ctrl_wr),
  .flags        (flags),
  .evt_pulse    (evt_pulse),
  .clr_vec      (clr_vec),
  .irq          (irq),
  .dma_tx_req   (dma_tx_req),
  .line_release (line_release)
);

// File: tb/i2c_ctl_flags_tb.sv
module i2c_ctl_flags_tb;
  // encodings from the requirements
  localparam int EN = 0, ERR_IE = 1, TC_IE = 2, STOP_IE = 3, ADDR_IE = 5;
  localparam int TX_IE = 7, TXDMA = 14, RXDMA = 15, GC = 16, ADDR_AC = 17, STOP_AC = 18;
  localparam int TX = 0, RX = 1, AD = 2, ST = 4, TC = 5, TCR = 6, ARLO = 7, BERR = 8, OVR = 9;

  logic        clk = 0;
  logic        rst = 1;
  logic        bus_sel = 0, bus_we = 0;
  logic [1:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [9:0]  evt_pulse = 0;
  logic [6:0]  rx_addr = 0;
  logic        rx_addr_vld = 0;
  logic        gc_ack, irq, dma_tx_req, dma_rx_req, line_release;
  logic [3:0]  cfg_filt_len;
  logic        cfg_anoff, cfg_nostretch;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  i2c_ctl_flags u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
    .rx_addr(rx_addr), .rx_addr_vld(rx_addr_vld), .gc_ack(gc_ack), .irq(irq),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req), .line_release(line_release),
    .cfg_filt_len(cfg_filt_len), .cfg_anoff(cfg_anoff), .cfg_nostretch(cfg_nostretch)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic pulse(logic [9:0] e);
    @(negedge clk);
    evt_pulse = e;
    @(negedge clk);
    evt_pulse = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 release", {31'b0, line_release}, 1);
    check("R1 irq/dma/gc", {28'b0, irq, dma_tx_req, dma_rx_req, gc_ack}, 0);
    rd(0, d); check("R1 ctrl", d, 0);
    rd(1, d); check("R1 status", d, 0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    wr(0, 32'h1);
    pulse(10'h3FF);
    rd(1, d); check("R12 all flags", d, 32'h3FF);
    wr(2, 32'h005);
    rd(1, d); check("R12 partial clear", d, 32'h3FA);
    rd(2, d); check("R12 clear reads 0", d, 0);
    wr(2, 32'h3FA);
    rd(1, d); check("R12 cleared", d, 0);
  endtask

  task automatic t_per_source();
    wr(0, (1 << EN) | (1 << TX_IE));
    pulse(1 << RX); tick(1);
    check("R4 masked rx", {31'b0, irq}, 0);
    pulse(1 << TX); tick(1);
    check("R4 tx irq", {31'b0, irq}, 1);
    tick(3);
    check("R4 irq level held", {31'b0, irq}, 1);
    wr(2, 1 << TX); tick(1);
    check("R4 irq after clear", {31'b0, irq}, 0);
    wr(2, 32'h3FF);
  endtask

  task automatic t_tc();
    wr(0, (1 << EN) | (1 << TC_IE));
    pulse(1 << TCR); tick(1);
    check("R5 reload irq", {31'b0, irq}, 1);
    wr(2, 1 << TCR); tick(1);
    check("R5 reload cleared", {31'b0, irq}, 0);
    pulse(1 << TC); tick(1);
    check("R5 tc irq", {31'b0, irq}, 1);
    wr(2, 32'h3FF);
  endtask

  task automatic t_err();
    int srcs[3] = '{ARLO, BERR, OVR};
    wr(0, (1 << EN) | (1 << ERR_IE));
    for (int i = 0; i < 3; i++) begin
      pulse(10'(1 << srcs[i])); tick(1);
      check("R6 error irq", {31'b0, irq}, 1);
      wr(2, 32'h3FF); tick(1);
      check("R6 error cleared", {31'b0, irq}, 0);
    end
  endtask

  task automatic t_autoclr();
    logic [31:0] d;
    wr(0, (1 << EN) | (1 << ADDR_IE) | (1 << STOP_IE));
    pulse((1 << AD) | (1 << ST));
    rd(1, d); check("R7 R8 flags set", d, (1 << AD) | (1 << ST));
    wr(2, 1 << AD);
    rd(1, d); check("R7 addr clear", d, 1 << ST);
    wr(2, 1 << ST);
    rd(1, d); check("R8 stop clear", d, 0);
    wr(0, (1 << EN) | (1 << ADDR_IE) | (1 << STOP_IE) | (1 << ADDR_AC));
    pulse(1 << AD); tick(1);
    check("R7 autoclr irq", {31'b0, irq}, 0);
    rd(1, d); check("R7 autoclr flag", d, 0);
    wr(0, (1 << EN) | (1 << ADDR_IE) | (1 << STOP_IE) | (1 << STOP_AC));
    pulse(1 << ST); tick(1);
    check("R8 autoclr irq", {31'b0, irq}, 0);
    rd(1, d); check("R8 autoclr flag", d, 0);
  endtask

  task automatic t_gc();
    wr(0, 1 << EN);
    @(negedge clk); rx_addr = 0; rx_addr_vld = 1;
    @(negedge clk); rx_addr_vld = 0;
    check("R9 gc disabled", {31'b0, gc_ack}, 0);
    wr(0, (1 << EN) | (1 << GC));
    @(negedge clk); rx_addr = 0; rx_addr_vld = 1;
    @(negedge clk); rx_addr_vld = 0;
    check("R9 gc enabled", {31'b0, gc_ack}, 1);
    @(negedge clk); rx_addr = 7'h2A; rx_addr_vld = 1;
    @(negedge clk); rx_addr_vld = 0;
    check("R9 nonzero addr", {31'b0, gc_ack}, 0);
  endtask

  task automatic t_dma();
    wr(0, (1 << EN) | (1 << TXDMA));
    pulse(1 << RX); tick(1);
    check("R10 tx req from rx", {31'b0, dma_tx_req}, 0);
    pulse(1 << TX); tick(1);
    check("R10 tx req", {30'b0, dma_tx_req, dma_rx_req}, 2'b10);
    wr(0, (1 << EN) | (1 << TXDMA) | (1 << RXDMA)); tick(1);
    check("R10 rx req", {31'b0, dma_rx_req}, 1);
    wr(2, 32'h3FF); tick(1);
    check("R10 reqs drop", {30'b0, dma_tx_req, dma_rx_req}, 0);
  endtask

  task automatic t_setwins();
    logic [31:0] d;
    wr(0, 1 << EN);
    pulse(1 << TX);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 2; bus_wdata = 1 << TX; evt_pulse = 1 << TX;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; evt_pulse = 0;
    rd(1, d); check("R11 set wins", d, 1 << TX);
    wr(2, 1 << TX);
    rd(1, d); check("R11 later clear", d, 0);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(0, 1 << EN);
    wr(0, 32'h0000_3500);
    rd(0, d); check("R3 locked while enabled", d, 0);
    check("R3 cfg outputs", {26'b0, cfg_filt_len, cfg_anoff, cfg_nostretch}, 0);
    wr(0, 32'h0000_3500);
    rd(0, d); check("R3 written while disabled", d, 32'h0000_3500);
    check("R3 cfg outputs set", {26'b0, cfg_filt_len, cfg_anoff, cfg_nostretch}, 32'h17);
    wr(0, 0);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    wr(0, (1 << EN) | (1 << TX_IE));
    pulse(1 << TX); tick(1);
    check("R2 irq before", {31'b0, irq}, 1);
    wr(0, 0); tick(2);
    check("R2 irq off", {30'b0, irq, line_release}, 2'b01);
    rd(1, d); check("R2 flags cleared", d, 0);
    pulse(1 << TX);
    wr(0, (1 << EN) | (1 << TX_IE));
    rd(1, d); check("R2 no stale flag", d, 0);
    check("R2 lines driven", {31'b0, line_release}, 0);
  endtask

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    t_reset();
    t_layout();
    t_per_source();
    t_tc();
    t_err();
    t_autoclr();
    t_gc();
    t_dma();
    t_setwins();
    t_lock();
    t_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule